// File: doc/BRIEF.md
# Cluster Power-Down Sequencer

This controller steps a processor cluster (a core and its level-2 cache) from normal operation to a state in which the system may safely remove power. It does not perform the flush, switch the power rails or gate the clock itself. It only watches the cluster's progress and reports to the system when the cluster has reached the point where it can be switched off.

The walk is fixed. The cluster first sits idle. When the core asks for a cache flush, the block waits for the flush to complete. It then waits for the core to halt in wait-for-interrupt, and then for the coherency handshake to fall fully quiet. At that point it raises a ready-for-power-off indication. The block also produces the cluster reset, which is the external reset combined with an active-low software reset from the system. It registers a clock-gate request that the system's clock-gating cell uses while that software reset holds the cluster down after a power-off request.

Top module: `pdseq_top`

## Requirements
- R1: `cluster_rst` is high whenever `rst` is high or the effective software reset is low. While `cluster_rst` is high, the sequencer is forced to idle immediately, without waiting for a clock edge, and `pwr_off_rdy` is low.
- R2: From idle, the sequencer moves to the flush stage on a rising clock edge only if `flush_req` is high. Otherwise it stays idle.
- R3: In the flush stage, the sequencer stays put until a clock edge samples `flush_done` high. It then moves to the halt-wait stage.
- R4: In the halt-wait stage, the sequencer stays put until a clock edge samples `core_halted` high. It then moves to the coherency-exit stage.
- R5: In the coherency-exit stage, the sequencer advances to power-off request only on an edge where both `coh_req` and `coh_ack` are low. If either one is high, it stays.
- R6: `pwr_off_rdy` is high exactly while the sequencer is in the power-off request stage. The sequencer advances at most one stage per clock, so with every condition already met, `pwr_off_rdy` rises after the fourth edge out of idle.
- R7: Once the sequencer is in the power-off request stage, it stays there until `cluster_rst` asserts, whatever the other inputs do.
- R8: After the power-off request stage has been reached, `pd_clk_gate` goes high on the first clock edge that samples `sw_rst_n` low. It stays high while `sw_rst_n` remains low.
- R9: `pd_clk_gate` drops on the first edge that samples `sw_rst_n` high. A software reset that is not preceded by a power-off request never raises `pd_clk_gate`. Both the request memory and `pd_clk_gate` clear on a clock edge with `rst` high.
- R10: With parameter `LOW_POWER_IF` set to 0, `sw_rst_n` has no effect: the effective software reset stays inactive (high), `cluster_rst` follows `rst` alone, and `pd_clk_gate` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated cluster clock |
| rst | input | 1 | External reset, active high |
| sw_rst_n | input | 1 | Software reset from the system, active low |
| flush_req | input | 1 | Core asks for a cache flush before power-down |
| flush_done | input | 1 | Cache flush has completed |
| core_halted | input | 1 | Core is halted in wait-for-interrupt |
| coh_req | input | 1 | Coherency request handshake signal |
| coh_ack | input | 1 | Coherency acknowledge handshake signal |
| cluster_rst | output | 1 | Combined cluster reset, active high |
| pwr_off_rdy | output | 1 | Cluster is idle and ready for power removal |
| pd_clk_gate | output | 1 | Registered clock-gate request during power-down reset |

## Verification
A table of per-cycle input vectors drives the sequence from reset. Each stage is held back by exactly the input it waits on, while the inputs of later stages are already satisfied. A stage that advances early therefore shows up as an early `pwr_off_rdy`. In the coherency-exit stage the table tries request high alone, acknowledge high alone, and both high, which separates a correct both-low test from a test on only one of the two signals. Directed sequences then apply the software reset with and without a preceding power-off request, which separates a qualified clock-gate request from one driven by the software reset alone. A second instance built without the low-power interface shows that `sw_rst_n` is ignored there.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  // Stage encoding: only the power-off request stage has the top bit set,
  // so the ready output is a single flop bit with no decode.
  typedef enum logic [2:0] {
    PS_IDLE      = 3'b000,
    PS_FLUSH     = 3'b001,
    PS_HALT_WAIT = 3'b010,
    PS_COH_EXIT  = 3'b011,
    PS_OFF_REQ   = 3'b100
  } pd_state_e;

  localparam int unsigned READY_BIT = 2;

endpackage

// File: rtl/pdseq_rst.sv
module pdseq_rst #(
  parameter bit LOW_POWER_IF = 1'b1
) (
  input  logic rst_i,
  input  logic sw_rst_n_i,
  output logic sw_rst_eff_n_o,
  output logic cluster_rst_o
);

  generate
    if (LOW_POWER_IF) begin : g_lp
      assign sw_rst_eff_n_o = sw_rst_n_i;
    end else begin : g_nolp
      // Interface absent: software reset reads as permanently inactive.
      assign sw_rst_eff_n_o = sw_rst_n_i | 1'b1;
    end
  endgenerate

  assign cluster_rst_o = rst_i | ~sw_rst_eff_n_o;

  // R1
  always_comb begin
    if (rst_i) begin
      cluster_rst_follows_ext_chk: assert (cluster_rst_o);
    end
  end

endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      cluster_rst_i,
  input  logic      flush_req_i,
  input  logic      flush_done_i,
  input  logic      core_halted_i,
  input  logic      coh_req_i,
  input  logic      coh_ack_i,
  output pd_state_e state_o,
  output logic      off_req_o
);

  pd_state_e state_q;
  pd_state_e state_d;
  logic      coh_quiet;

  assign coh_quiet = ~coh_req_i & ~coh_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:      if (flush_req_i)   state_d = PS_FLUSH;
      PS_FLUSH:     if (flush_done_i)  state_d = PS_HALT_WAIT;
      PS_HALT_WAIT: if (core_halted_i) state_d = PS_COH_EXIT;
      PS_COH_EXIT:  if (coh_quiet)     state_d = PS_OFF_REQ;
      PS_OFF_REQ:                      state_d = PS_OFF_REQ;
      default:                         state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge cluster_rst_i) begin
    if (cluster_rst_i) state_q <= PS_IDLE;
    else               state_q <= state_d;
  end

  assign state_o   = state_q;
  assign off_req_o = state_q[READY_BIT];

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (cluster_rst_i)
    (state_q == PS_IDLE && !flush_req_i) |=> (state_q == PS_IDLE));

  // R3
  flush_hold_chk: assert property (@(posedge clk) disable iff (cluster_rst_i)
    (state_q == PS_FLUSH && !flush_done_i) |=> (state_q == PS_FLUSH));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (cluster_rst_i)
    (state_q == PS_HALT_WAIT && !core_halted_i) |=> (state_q == PS_HALT_WAIT));

  // R5
  coh_hold_chk: assert property (@(posedge clk) disable iff (cluster_rst_i)
    (state_q == PS_COH_EXIT && (coh_req_i || coh_ack_i)) |=> (state_q == PS_COH_EXIT));

  // R7
  off_sticky_chk: assert property (@(posedge clk) disable iff (cluster_rst_i)
    (state_q == PS_OFF_REQ) |=> (state_q == PS_OFF_REQ));

  // R6
  off_entry_chk: assert property (@(posedge clk) disable iff (cluster_rst_i)
    $rose(off_req_o) |-> ($past(state_q) == PS_COH_EXIT));

endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate (
  input  logic clk,
  input  logic rst_i,
  input  logic sw_rst_eff_n_i,
  input  logic off_req_i,
  output logic pd_gate_o
);

  // Remembers that a power-off request was reached, so the request
  // survives the software reset that sends the sequencer back to idle.
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      armed_q   <= 1'b0;
      pd_gate_o <= 1'b0;
    end else begin
      if (off_req_i)           armed_q <= 1'b1;
      else if (sw_rst_eff_n_i) armed_q <= 1'b0;
      pd_gate_o <= ~sw_rst_eff_n_i & armed_q;
    end
  end

  // R8
  gate_needs_swrst_chk: assert property (@(posedge clk) disable iff (rst_i)
    pd_gate_o |-> $past(!sw_rst_eff_n_i));

  // R9
  gate_needs_request_chk: assert property (@(posedge clk) disable iff (rst_i)
    $rose(pd_gate_o) |-> $past(armed_q));

  // R9
  gate_release_chk: assert property (@(posedge clk) disable iff (rst_i)
    (pd_gate_o && sw_rst_eff_n_i) |=> !pd_gate_o);

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter bit LOW_POWER_IF = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_rst_n,
  input  logic flush_req,
  input  logic flush_done,
  input  logic core_halted,
  input  logic coh_req,
  input  logic coh_ack,
  output logic cluster_rst,
  output logic pwr_off_rdy,
  output logic pd_clk_gate
);

  logic      sw_rst_eff_n;
  logic      off_req;
  pd_state_e state;

  pdseq_rst #(.LOW_POWER_IF(LOW_POWER_IF)) u_rst (
    .rst_i          (rst),
    .sw_rst_n_i     (sw_rst_n),
    .sw_rst_eff_n_o (sw_rst_eff_n),
    .cluster_rst_o  (cluster_rst)
  );

  pdseq_fsm u_fsm (
    .clk           (clk),
    .cluster_rst_i (cluster_rst),
    .flush_req_i   (flush_req),
    .flush_done_i  (flush_done),
    .core_halted_i (core_halted),
    .coh_req_i     (coh_req),
    .coh_ack_i     (coh_ack),
    .state_o       (state),
    .off_req_o     (off_req)
  );

  pdseq_gate u_gate (
    .clk            (clk),
    .rst_i          (rst),
    .sw_rst_eff_n_i (sw_rst_eff_n),
    .off_req_i      (off_req),
    .pd_gate_o      (pd_clk_gate)
  );

  assign pwr_off_rdy = off_req;

  // R6
  ready_matches_stage_chk: assert property (@(posedge clk) disable iff (cluster_rst)
    pwr_off_rdy |-> (state == PS_OFF_REQ));

endmodule

// File: tb/tb_pdseq_top.sv
module tb_pdseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_rst_n = 1'b1;
  logic flush_req = 1'b0, flush_done = 1'b0, core_halted = 1'b0;
  logic coh_req = 1'b0, coh_ack = 1'b0;
  logic cluster_rst, pwr_off_rdy, pd_clk_gate;
  logic nl_cluster_rst, nl_pwr_off_rdy, nl_pd_clk_gate;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdseq_top #(.LOW_POWER_IF(1'b1)) dut (
    .clk(clk), .rst(rst), .sw_rst_n(sw_rst_n), .flush_req(flush_req),
    .flush_done(flush_done), .core_halted(core_halted), .coh_req(coh_req),
    .coh_ack(coh_ack), .cluster_rst(cluster_rst), .pwr_off_rdy(pwr_off_rdy),
    .pd_clk_gate(pd_clk_gate)
  );

  pdseq_top #(.LOW_POWER_IF(1'b0)) dut_nolp (
    .clk(clk), .rst(rst), .sw_rst_n(sw_rst_n), .flush_req(flush_req),
    .flush_done(flush_done), .core_halted(core_halted), .coh_req(coh_req),
    .coh_ack(coh_ack), .cluster_rst(nl_cluster_rst), .pwr_off_rdy(nl_pwr_off_rdy),
    .pd_clk_gate(nl_pd_clk_gate)
  );

  // Row fields: {flush_req, flush_done, core_halted, coh_req, coh_ack, exp_rdy, exp_gate}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_1_1_0_0_0_0,  // R2: idle holds without flush_req
    7'b0_1_1_0_0_0_0,  // R2
    7'b1_0_1_0_0_0_0,  // R2: enter flush stage
    7'b0_0_1_0_0_0_0,  // R3: flush holds without flush_done
    7'b0_0_1_0_0_0_0,  // R3
    7'b0_1_0_0_0_0_0,  // R3: enter halt-wait
    7'b0_0_0_0_0_0_0,  // R4: halt-wait holds
    7'b0_0_1_1_0_0_0,  // R4: enter coherency exit
    7'b0_0_1_1_0_0_0,  // R5: request alone holds
    7'b0_0_1_0_1_0_0,  // R5: acknowledge alone holds
    7'b0_0_1_1_1_0_0,  // R5: both high holds
    7'b0_0_1_0_0_1_0,  // R6: both low -> power-off request
    7'b0_0_0_1_1_1_0,  // R7: sticky
    7'b0_0_0_0_0_1_0   // R7
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic fr, input logic fd, input logic h,
                        input logic cr, input logic ca);
    flush_req = fr; flush_done = fd; core_halted = h; coh_req = cr; coh_ack = ca;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    step();
    chk("R1 reset cluster_rst", cluster_rst, 1'b1);
    chk("R1 reset pwr_off_rdy", pwr_off_rdy, 1'b0);
    chk("R9 reset pd_clk_gate", pd_clk_gate, 1'b0);
    rst = 1'b0;
    #1;
    chk("R1 released cluster_rst", cluster_rst, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      set_in(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      step();
      chk($sformatf("R6 table row %0d rdy", i), pwr_off_rdy, VEC[i][1]);
      chk($sformatf("R10 table row %0d nolp rdy", i), nl_pwr_off_rdy, VEC[i][1]);
      chk($sformatf("R9 table row %0d gate", i), pd_clk_gate, VEC[i][0]);
    end

    // Software reset after a power-off request
    sw_rst_n = 1'b0;
    #1;
    chk("R1 sw reset cluster_rst", cluster_rst, 1'b1);
    chk("R1 sw reset async idle", pwr_off_rdy, 1'b0);
    chk("R10 nolp cluster_rst", nl_cluster_rst, 1'b0);
    chk("R10 nolp stays ready", nl_pwr_off_rdy, 1'b1);
    step();
    chk("R8 gate set", pd_clk_gate, 1'b1);
    chk("R10 nolp gate", nl_pd_clk_gate, 1'b0);
    step();
    chk("R8 gate held", pd_clk_gate, 1'b1);
    sw_rst_n = 1'b1;
    step();
    chk("R9 gate released", pd_clk_gate, 1'b0);
    chk("R1 cluster_rst released", cluster_rst, 1'b0);
    chk("R2 idle after sw reset", pwr_off_rdy, 1'b0);

    // Software reset with no preceding request
    sw_rst_n = 1'b0;
    step();
    chk("R9 no request no gate", pd_clk_gate, 1'b0);
    step();
    chk("R9 no request no gate later", pd_clk_gate, 1'b0);
    sw_rst_n = 1'b1;
    step();

    // All conditions met up front: four edges to ready
    set_in(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(); step(); step();
    chk("R6 not ready after three edges", pwr_off_rdy, 1'b0);
    step();
    chk("R6 ready after four edges", pwr_off_rdy, 1'b1);

    // External reset forces idle at once
    rst = 1'b1;
    #1;
    chk("R1 ext reset async idle", pwr_off_rdy, 1'b0);
    chk("R1 ext reset cluster_rst", cluster_rst, 1'b1);
    chk("R10 nolp ext reset", nl_cluster_rst, 1'b1);
    step();
    rst = 1'b0;
    set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R2 idle after ext reset", pwr_off_rdy, 1'b0);
    sw_rst_n = 1'b0;
    step();
    chk("R9 request cleared by ext reset", pd_clk_gate, 1'b0);
    sw_rst_n = 1'b1;
    step();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule